// File: doc/BRIEF.md
# Triplicated Output Pin Voter

This block drives one external line of `WIDTH` bits from three redundant channels. No single voter gate decides the line. Each channel owns a state register, a minority voter and a tri-state driver. The three drivers are tied onto one shared net.

A channel's driver is enabled only on the bits where its own copy matches the other two copies by majority. Its enable is active low. A channel that disagrees on a bit releases that bit to high impedance, and the two agreeing channels hold the line.

Each channel runs on its own clock. All three clocks are synchronous to each other. Each channel takes its own copy of the data and of the load strobe. Every register copy computes its own majority of all three copies. When it is not loading, it takes that majority as its next state. A copy that was upset, or was loaded with a divergent value, therefore returns to agreement at the next edge.

Top module: `tmr_pin_voter`

## Requirements
- R1: While `rst_ni` is low, all three register copies are 0. The line and `vote_o` read 0, every `oe_n_*_o` bit is 0 (driving), and `err_o` is 3'b000.
- R2: On an edge where a channel's load strobe is high, that copy takes its own data input. When all three load equal data, all three copies and the line show that data after the edge.
- R3: On an edge where a channel's load strobe is low, that copy takes the bitwise majority of the three copies, so a state on which all copies agree is held.
- R4: After an edge that leaves one copy different from the other two, the next edge without loads brings all three copies back into agreement on the majority value.
- R5: Bit i of `oe_n_x_o` is 0 (drive) exactly when bit i of channel x's copy equals at least one of the two other copies' bit i. Otherwise it is 1 (released).
- R6: Bit i of the line equals the majority of the three copies' bit i. At least two drivers are enabled on every bit, and all enabled drivers carry the same value.
- R7: Bit 0/1/2 of `err_o` (channels a/b/c) is high exactly in the cycles where any bit of that channel's copy differs from the majority. With no loads, a raised flag lasts one cycle.
- R8: Voting is independent per bit. Different channels may be in the minority on different bits in the same cycle, and each bit is resolved on its own.
- R9: `vote_o` is the bitwise majority of the three register copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Clock of channel a |
| clk_b_i | input | 1 | Clock of channel b (synchronous to a) |
| clk_c_i | input | 1 | Clock of channel c (synchronous to a) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_a_i | input | 1 | Load strobe, channel a copy |
| ld_b_i | input | 1 | Load strobe, channel b copy |
| ld_c_i | input | 1 | Load strobe, channel c copy |
| d_a_i | input | WIDTH | Data copy for channel a |
| d_b_i | input | WIDTH | Data copy for channel b |
| d_c_i | input | WIDTH | Data copy for channel c |
| pin_o | output | WIDTH | Shared tri-state line driven by the three channels |
| oe_n_a_o | output | WIDTH | Active-low driver enables, channel a |
| oe_n_b_o | output | WIDTH | Active-low driver enables, channel b |
| oe_n_c_o | output | WIDTH | Active-low driver enables, channel c |
| err_o | output | 3 | Per-channel mismatch flags (bit0 a, bit1 b, bit2 c) |
| vote_o | output | WIDTH | Bitwise majority of the three register copies |

## Verification
Self-healing and fresh loading can land on the same edge. One copy is being pulled back to the majority while a different channel loads a divergent value. This leaves a new minority on a different channel in the very next cycle. The bench provokes it by following a divergent load on channel a with a divergent load on channel b. It also loads values that leave channels a and b in the minority on different bits at once. A scoreboard with an independent copy model judges every cycle's enables, flags, vote and line.

// File: rtl/tmr_pin_pkg.sv
`timescale 1ns/1ps
package tmr_pin_pkg;
  localparam int unsigned NCH = 3;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/tmr_state_cell.sv
`timescale 1ns/1ps
// One register copy; next state is its own majority of all copies unless loading.
module tmr_state_cell #(
  parameter int unsigned WIDTH = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              ld_i,
  input  logic [WIDTH-1:0]                  d_i,
  input  logic [tmr_pin_pkg::NCH-1:0][WIDTH-1:0] q_all_i,
  output logic [WIDTH-1:0]                  q_o
);
  logic [WIDTH-1:0] fb_vote;

  for (genvar b = 0; b < WIDTH; b++) begin : g_fb
    assign fb_vote[b] = tmr_pin_pkg::maj3(q_all_i[0][b], q_all_i[1][b], q_all_i[2][b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= ld_i ? d_i : fb_vote;
  end
endmodule

// File: rtl/tmr_minority_voter.sv
`timescale 1ns/1ps
// Per-bit minority voter: releases the driver where the primary is outvoted.
module tmr_minority_voter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] prim_i,
  input  logic [WIDTH-1:0] alt0_i,
  input  logic [WIDTH-1:0] alt1_i,
  output logic [WIDTH-1:0] oe_n_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic agree;
    assign agree     = (prim_i[b] == alt0_i[b]) | (prim_i[b] == alt1_i[b]);
    assign oe_n_o[b] = ~agree;
  end
endmodule

// File: rtl/tmr_pin_voter.sv
`timescale 1ns/1ps
module tmr_pin_voter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_a_i,
  input  logic             clk_b_i,
  input  logic             clk_c_i,
  input  logic             rst_ni,
  input  logic             ld_a_i,
  input  logic             ld_b_i,
  input  logic             ld_c_i,
  input  logic [WIDTH-1:0] d_a_i,
  input  logic [WIDTH-1:0] d_b_i,
  input  logic [WIDTH-1:0] d_c_i,
  output wire  [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] oe_n_a_o,
  output logic [WIDTH-1:0] oe_n_b_o,
  output logic [WIDTH-1:0] oe_n_c_o,
  output logic [2:0]       err_o,
  output logic [WIDTH-1:0] vote_o
);
  localparam int unsigned NCH = tmr_pin_pkg::NCH;

  logic [NCH-1:0]            clk_v;
  logic [NCH-1:0]            ld_v;
  logic [NCH-1:0][WIDTH-1:0] d_v;
  logic [NCH-1:0][WIDTH-1:0] q_v;
  logic [NCH-1:0][WIDTH-1:0] oe_n_v;

  assign clk_v = {clk_c_i, clk_b_i, clk_a_i};
  assign ld_v  = {ld_c_i, ld_b_i, ld_a_i};
  assign d_v   = {d_c_i, d_b_i, d_a_i};

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    tmr_state_cell #(.WIDTH(WIDTH)) i_cell (
      .clk_i   (clk_v[k]),
      .rst_ni  (rst_ni),
      .ld_i    (ld_v[k]),
      .d_i     (d_v[k]),
      .q_all_i (q_v),
      .q_o     (q_v[k])
    );

    tmr_minority_voter #(.WIDTH(WIDTH)) i_mvote (
      .prim_i (q_v[k]),
      .alt0_i (q_v[(k+1)%NCH]),
      .alt1_i (q_v[(k+2)%NCH]),
      .oe_n_o (oe_n_v[k])
    );

    // active-low tri-state drivers, all on one net
    for (genvar b = 0; b < WIDTH; b++) begin : g_drv
      assign pin_o[b] = oe_n_v[k][b] ? 1'bz : q_v[k][b];
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_vote
    assign vote_o[b] = tmr_pin_pkg::maj3(q_v[0][b], q_v[1][b], q_v[2][b]);
  end

  for (genvar k = 0; k < NCH; k++) begin : g_err
    assign err_o[k] = |(q_v[k] ^ vote_o);
  end

  assign oe_n_a_o = oe_n_v[0];
  assign oe_n_b_o = oe_n_v[1];
  assign oe_n_c_o = oe_n_v[2];
endmodule

// File: rtl/tmr_pin_voter_chk.sv
`timescale 1ns/1ps
module tmr_pin_voter_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [2:0]            ld_i,
  input logic [WIDTH-1:0]      d_a_i,
  input logic [WIDTH-1:0]      d_b_i,
  input logic [WIDTH-1:0]      d_c_i,
  input logic [2:0][WIDTH-1:0] q_i,
  input logic [WIDTH-1:0]      vote_i,
  input logic [WIDTH-1:0]      oe_n_a_i,
  input logic [WIDTH-1:0]      oe_n_b_i,
  input logic [WIDTH-1:0]      oe_n_c_i,
  input logic [2:0]            err_i
);
  AST_LOAD_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i == 3'b111 && d_a_i == d_b_i && d_b_i == d_c_i)
      |=> (q_i[0] == $past(d_a_i) && q_i[1] == $past(d_a_i) && q_i[2] == $past(d_a_i))); // R2

  AST_HEAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i == 3'b000) |=> (q_i[0] == q_i[1] && q_i[1] == q_i[2])); // R4

  AST_ENABLE_AGREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((q_i[0] ^ vote_i) & ~oe_n_a_i) == '0) && (((q_i[1] ^ vote_i) & ~oe_n_b_i) == '0)
      && (((q_i[2] ^ vote_i) & ~oe_n_c_i) == '0)); // R5

  AST_QUORUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((oe_n_a_i & oe_n_b_i) | (oe_n_a_i & oe_n_c_i) | (oe_n_b_i & oe_n_c_i)) == '0); // R6

  AST_FLAG_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i == {|oe_n_c_i, |oe_n_b_i, |oe_n_a_i}); // R7

  AST_FLAG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i != 3'b000 && ld_i == 3'b000) |=> (err_i == 3'b000)); // R7
endmodule

bind tmr_pin_voter tmr_pin_voter_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_i    (clk_a_i),
  .rst_ni   (rst_ni),
  .ld_i     ({ld_c_i, ld_b_i, ld_a_i}),
  .d_a_i    (d_a_i),
  .d_b_i    (d_b_i),
  .d_c_i    (d_c_i),
  .q_i      (q_v),
  .vote_i   (vote_o),
  .oe_n_a_i (oe_n_a_o),
  .oe_n_b_i (oe_n_b_o),
  .oe_n_c_i (oe_n_c_o),
  .err_i    (err_o)
);

// File: tb/test_tmr_pin_voter.sv
`timescale 1ns/1ps
module test_tmr_pin_voter;
  localparam int unsigned W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ld_a = 1'b0, ld_b = 1'b0, ld_c = 1'b0;
  logic [W-1:0] d_a = '0, d_b = '0, d_c = '0;
  wire  [W-1:0] pin;
  logic [W-1:0] oe_n_a, oe_n_b, oe_n_c, vote;
  logic [2:0]   err;

  always #2 clk = ~clk; // 250 MHz

  tmr_pin_voter #(.WIDTH(W)) i_tmr_pin_voter (
    .clk_a_i(clk), .clk_b_i(clk), .clk_c_i(clk), .rst_ni(rst_ni),
    .ld_a_i(ld_a), .ld_b_i(ld_b), .ld_c_i(ld_c),
    .d_a_i(d_a), .d_b_i(d_b), .d_c_i(d_c),
    .pin_o(pin), .oe_n_a_o(oe_n_a), .oe_n_b_o(oe_n_b), .oe_n_c_o(oe_n_c),
    .err_o(err), .vote_o(vote)
  );

  typedef struct packed {
    logic [W-1:0] qa;
    logic [W-1:0] qb;
    logic [W-1:0] qc;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  model = '0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  task automatic chk(string tag, string what, logic [W-1:0] got, logic [W-1:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, expv);
    end
  endtask

  function automatic logic [W-1:0] bmaj(exp_t e);
    logic [W-1:0] m;
    for (int b = 0; b < W; b++) begin
      int ones;
      ones = int'(e.qa[b]) + int'(e.qb[b]) + int'(e.qc[b]);
      m[b] = (ones >= 2);
    end
    return m;
  endfunction

  task automatic judge(string tag, exp_t e);
    logic [W-1:0] m;
    logic [W-1:0] ea, eb, ec;
    logic [W-1:0] quorum_bad;
    m  = bmaj(e);
    ea = e.qa ^ m;
    eb = e.qb ^ m;
    ec = e.qc ^ m;
    chk(tag, "R9 vote", vote, m);
    chk(tag, "R6 line", pin, m);
    chk(tag, "R5 oe_n_a", oe_n_a, ea);
    chk(tag, "R5 oe_n_b", oe_n_b, eb);
    chk(tag, "R5 oe_n_c", oe_n_c, ec);
    chk(tag, "R7 err", {5'b0, err}, {5'b0, |ec, |eb, |ea});
    for (int b = 0; b < W; b++)
      quorum_bad[b] = (int'(!oe_n_a[b]) + int'(!oe_n_b[b]) + int'(!oe_n_c[b])) < 2;
    chk(tag, "R6 quorum", quorum_bad, '0);
  endtask

  // driver: apply one cycle of stimulus, predict the copies after the edge
  task automatic step(string tag, logic la, logic lb, logic lc,
                      logic [W-1:0] va, logic [W-1:0] vb, logic [W-1:0] vc);
    logic [W-1:0] m;
    @(negedge clk);
    ld_a = la; ld_b = lb; ld_c = lc;
    d_a = va;  d_b = vb;  d_c = vc;
    m = bmaj(model);
    model.qa = la ? va : m;
    model.qb = lb ? vb : m;
    model.qc = lc ? vc : m;
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 1'b0, 1'b0, '0, '0, '0);
  endtask

  // monitor: compare just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0 && rst_ni) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        judge(t, e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    judge("R1 reset", '0);
    @(negedge clk);
    rst_ni = 1'b1;
    idle("R1 after release");
    // R2: coherent load
    step("R2 load", 1'b1, 1'b1, 1'b1, 8'hA5, 8'hA5, 8'hA5);
    // R3: hold
    idle("R3 hold0");
    idle("R3 hold1");
    // R4/R7: channel a loads a divergent copy, then heals
    step("R4 upset a", 1'b1, 1'b1, 1'b1, 8'h5A, 8'hA5, 8'hA5);
    idle("R4 heal a");
    idle("R7 flag gone");
    // R8: a minority on bit0, b minority on bit7 in the same cycle
    step("R8 split", 1'b1, 1'b1, 1'b1, 8'hA4, 8'h25, 8'hA5);
    idle("R8 heal");
    // only channel c loads: c becomes the minority
    step("R4 lone c", 1'b0, 1'b0, 1'b1, '0, '0, 8'h3C);
    idle("R4 heal c");
    // two channels load: new majority takes over, c heals to it
    step("R2 two load", 1'b1, 1'b1, 1'b0, 8'h3C, 8'h3C, 8'hFF);
    idle("R3 new maj");
    // heal of a coinciding with a divergent load on b
    step("R4 upset a2", 1'b1, 1'b0, 1'b0, 8'hC3, '0, '0);
    step("R4 heal a + load b", 1'b0, 1'b1, 1'b0, '0, 8'h0F, '0);
    idle("R4 heal b");
    // two channels agree against c on some bits, disagree on others
    step("R8 mixed", 1'b1, 1'b1, 1'b1, 8'hF0, 8'hCC, 8'hAA);
    idle("R3 hold mixed");
    @(posedge clk);
    #2;
    // R1: reset mid-run
    rst_ni = 1'b0;
    #1;
    judge("R1 mid reset", '0);
    model = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    idle("R1 post reset hold");
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule